// File: doc/BRIEF.md
# Partial Reconfiguration Session Sequencer

This block runs the control side of one partial reconfiguration session on a programmable fabric. A host pulses `start_i`. The sequencer checks the configuration mode strap and the two configuration pins. It then brings up chip select, the configuration path and the control overrides, in that order. It asks an external burst generator for two clock bursts, one of 256 pulses and one of 2047 pulses, with the PR request asserted between them. Next it polls the fabric for readiness. When the fabric is ready, it signals that a data mover may stream the image.

After the data mover has finished, the host pulses `finish_i`. The sequencer polls for completion and then tears the session down in a fixed order. The teardown always runs, whatever the polls returned. Last, it checks the fabric's health pins and reports a two-bit result with a one-cycle valid strobe. A separate combinational view condenses the fabric status into one of five states.

The states are IDLE, CHECK, CS_ON, PATH_ON, OVR_ON, REQ_ON, B_CLR0, B_GO, B_WAIT, B_CLR1, POLL_RDY, STREAM, POLL_DONE, TD_REQ, TD_PATH, TD_CS, TD_OVR, FINAL and REPORT.

The transitions are:
- IDLE to CHECK on start.
- CHECK to CS_ON if the entry test passes, otherwise CHECK to REPORT.
- CS_ON to PATH_ON to OVR_ON to the burst subsequence.
- The burst subsequence runs B_CLR0, B_GO, B_WAIT (held until the done level) and B_CLR1, then returns to REQ_ON, POLL_RDY or TD_PATH.
- REQ_ON to the burst subsequence.
- POLL_RDY to STREAM on ready. POLL_RDY to TD_REQ on an error or when the polls run out.
- STREAM to POLL_DONE on finish.
- POLL_DONE to TD_REQ on done, on an error or when the polls run out.
- TD_REQ to the burst subsequence.
- TD_PATH to TD_CS to TD_OVR to FINAL to REPORT to IDLE.

Top module: `prsess_ctrl`

## Requirements
- R1: In CHECK, a mode strap `msel_i` value other than 0 or 1 ends the session with result code 1 (invalid). No control output changes before the report.
- R2: In CHECK, `ncfg_pin_i` or `nstat_pin_i` low ends the session with result code 1. No control output changes before the report.
- R3: Bring-up order is: `chip_sel_n_o` falls, then one cycle later `path_en_o` rises, then one cycle later `ovr_en_o` rises.
- R4: Every burst is a one-cycle `brst_clr_o` pulse, then a one-cycle `brst_go_o` pulse with `brst_len_o` valid, then a wait until `brst_done_i` is high, then a one-cycle `brst_clr_o` pulse. A 256-pulse burst precedes `pr_req_o` rising, and a 2047-pulse burst follows it.
- R5: Readiness is sampled once per cycle, at most 10 times. An error on any poll wins over ready on the same poll and gives code 1. Ten polls without ready give code 2. Both failures go through the teardown before the report.
- R6: `stream_ok_o` is high only while waiting for `finish_i`. `finish_i` has no effect in any other state, and `start_i` has no effect while `busy_o` is high.
- R7: Completion is polled with the same 10-poll limit and the same error priority. A failure is held and reported only after the teardown.
- R8: Teardown order is: `pr_req_o` falls, then a 256-pulse burst, then `path_en_o` falls, then `chip_sel_n_o` rises, then `ovr_en_o` falls, each one cycle after the previous step.
- R9: After a clean teardown, if `umode_i`, `cdone_pin_i` or `nstat_pin_i` is low, the result is code 2.
- R10: The result codes are 0 ok, 1 invalid and 2 timeout. `res_vld_o` is high for exactly one cycle. `res_code_o` holds its value until the next report and is 0 after reset.
- R11: `view_o` is 1 (operating) if `umode_i` is high. Otherwise it is 2 (writing) if `pr_ready_i` is high, otherwise 3 (write error) if `crc_err_i` is high, otherwise 4 (in reset) if `nstat_pin_i` is low, otherwise 0 (unknown).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a session (pulse) |
| finish_i | input | 1 | Image streaming finished (pulse) |
| msel_i | input | 3 | Configuration mode strap |
| ncfg_pin_i | input | 1 | Configuration reset pin level |
| nstat_pin_i | input | 1 | Fabric status pin level |
| cdone_pin_i | input | 1 | Configuration done pin level |
| umode_i | input | 1 | Fabric in user mode |
| crc_err_i | input | 1 | Fabric CRC error flag |
| pr_ready_i | input | 1 | Fabric ready for partial image |
| pr_done_i | input | 1 | Fabric partial image accepted |
| pr_err_i | input | 1 | Fabric partial reconfiguration error |
| brst_done_i | input | 1 | Burst generator done level |
| brst_go_o | output | 1 | Burst launch pulse |
| brst_len_o | output | 12 | Pulse count for the burst |
| brst_clr_o | output | 1 | Clear the burst done flag |
| chip_sel_n_o | output | 1 | Active-low chip select |
| ovr_en_o | output | 1 | Control override enable |
| pr_req_o | output | 1 | Partial reconfiguration request |
| path_en_o | output | 1 | Configuration clock and data path enable |
| stream_ok_o | output | 1 | Data mover may stream |
| busy_o | output | 1 | Session in progress |
| res_vld_o | output | 1 | Result strobe |
| res_code_o | output | 2 | Result code |
| view_o | output | 3 | Condensed fabric status |

## Verification
The bench targets the poll boundaries:
- Ready on the tenth poll must be accepted. A design that counts one poll too few would report a timeout there.
- Ready and an error on the same poll must give invalid. A design with the wrong priority would start streaming instead.
- A completion error must appear only after overrides are released. A design that reports early would leave chip select and overrides asserted while it signals the result.

The bench also varies the burst done latency. This exposes a sequencer that launches the next step on a fixed delay instead of the done level. It raises `start_i` and `finish_i` in states where they must be ignored. It drives every combination of the four status-view inputs, which catches a wrong priority order.

// File: rtl/prsess_pkg.sv
package prsess_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CHECK,
        ST_CS_ON,
        ST_PATH_ON,
        ST_OVR_ON,
        ST_REQ_ON,
        ST_B_CLR0,
        ST_B_GO,
        ST_B_WAIT,
        ST_B_CLR1,
        ST_POLL_RDY,
        ST_STREAM,
        ST_POLL_DONE,
        ST_TD_REQ,
        ST_TD_PATH,
        ST_TD_CS,
        ST_TD_OVR,
        ST_FINAL,
        ST_REPORT
    } sess_state_t;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_INVALID = 2'd1,
        RES_TIMEOUT = 2'd2
    } res_code_t;

    typedef enum logic [2:0] {
        VIEW_UNKNOWN   = 3'd0,
        VIEW_OPERATING = 3'd1,
        VIEW_WRITING   = 3'd2,
        VIEW_WRITE_ERR = 3'd3,
        VIEW_IN_RESET  = 3'd4
    } fab_view_t;

endpackage

// File: rtl/prsess_entry_chk.sv
module prsess_entry_chk #(
    parameter int MSEL_W      = 3,
    parameter int MAX_PP_MODE = 1
) (
    input  logic [MSEL_W-1:0] msel_i,
    input  logic              ncfg_pin_i,
    input  logic              nstat_pin_i,
    output logic              entry_ok_o
);
    logic mode_ok;

    // only the passive parallel strap codes are accepted
    assign mode_ok    = (msel_i <= MSEL_W'(MAX_PP_MODE));
    // no outside agent may hold the fabric in reset
    assign entry_ok_o = mode_ok && ncfg_pin_i && nstat_pin_i;

endmodule

// File: rtl/prsess_poll_ctr.sv
module prsess_poll_ctr #(
    parameter int MAX_POLLS = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic last_o
);
    localparam int CNT_W = $clog2(MAX_POLLS + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (!last_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // high during the final permitted poll
    assign last_o = (cnt_q == CNT_W'(MAX_POLLS - 1));

endmodule

// File: rtl/prsess_view.sv
module prsess_view
    import prsess_pkg::*;
(
    input  logic      umode_i,
    input  logic      pr_ready_i,
    input  logic      crc_err_i,
    input  logic      nstat_pin_i,
    output fab_view_t view_o
);
    always_comb begin
        if (umode_i)           view_o = VIEW_OPERATING;
        else if (pr_ready_i)   view_o = VIEW_WRITING;
        else if (crc_err_i)    view_o = VIEW_WRITE_ERR;
        else if (!nstat_pin_i) view_o = VIEW_IN_RESET;
        else                   view_o = VIEW_UNKNOWN;
    end

endmodule

// File: rtl/prsess_ctrl.sv
module prsess_ctrl
    import prsess_pkg::*;
#(
    parameter int MSEL_W    = 3,
    parameter int LEN_W     = 12,
    parameter int FLUSH_LEN = 256,
    parameter int PREP_LEN  = 2047,
    parameter int MAX_POLLS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              finish_i,
    input  logic [MSEL_W-1:0] msel_i,
    input  logic              ncfg_pin_i,
    input  logic              nstat_pin_i,
    input  logic              cdone_pin_i,
    input  logic              umode_i,
    input  logic              crc_err_i,
    input  logic              pr_ready_i,
    input  logic              pr_done_i,
    input  logic              pr_err_i,
    input  logic              brst_done_i,
    output logic              brst_go_o,
    output logic [LEN_W-1:0]  brst_len_o,
    output logic              brst_clr_o,
    output logic              chip_sel_n_o,
    output logic              ovr_en_o,
    output logic              pr_req_o,
    output logic              path_en_o,
    output logic              stream_ok_o,
    output logic              busy_o,
    output logic              res_vld_o,
    output logic [1:0]        res_code_o,
    output logic [2:0]        view_o
);
    sess_state_t st_q, st_nxt, ret_q;
    res_code_t   err_q, res_q;
    logic        cs_n_q, ovr_q, req_q, path_q;
    logic [LEN_W-1:0] len_q;
    logic        entry_ok, poll_last, poll_clr, health_ok;
    fab_view_t   view_w;

    prsess_entry_chk #(
        .MSEL_W      (MSEL_W),
        .MAX_PP_MODE (1)
    ) u_entry (
        .msel_i      (msel_i),
        .ncfg_pin_i  (ncfg_pin_i),
        .nstat_pin_i (nstat_pin_i),
        .entry_ok_o  (entry_ok)
    );

    assign poll_clr = !((st_q == ST_POLL_RDY) || (st_q == ST_POLL_DONE));

    prsess_poll_ctr #(
        .MAX_POLLS (MAX_POLLS)
    ) u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (poll_clr),
        .last_o (poll_last)
    );

    prsess_view u_view (
        .umode_i     (umode_i),
        .pr_ready_i  (pr_ready_i),
        .crc_err_i   (crc_err_i),
        .nstat_pin_i (nstat_pin_i),
        .view_o      (view_w)
    );

    assign health_ok = umode_i && cdone_pin_i && nstat_pin_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:      if (start_i) st_nxt = ST_CHECK;
            ST_CHECK:     st_nxt = entry_ok ? ST_CS_ON : ST_REPORT;
            ST_CS_ON:     st_nxt = ST_PATH_ON;
            ST_PATH_ON:   st_nxt = ST_OVR_ON;
            ST_OVR_ON:    st_nxt = ST_B_CLR0;
            ST_REQ_ON:    st_nxt = ST_B_CLR0;
            ST_B_CLR0:    st_nxt = ST_B_GO;
            ST_B_GO:      st_nxt = ST_B_WAIT;
            ST_B_WAIT:    if (brst_done_i) st_nxt = ST_B_CLR1;
            ST_B_CLR1:    st_nxt = ret_q;
            ST_POLL_RDY: begin
                if (pr_err_i)        st_nxt = ST_TD_REQ;
                else if (pr_ready_i) st_nxt = ST_STREAM;
                else if (poll_last)  st_nxt = ST_TD_REQ;
            end
            ST_STREAM:    if (finish_i) st_nxt = ST_POLL_DONE;
            ST_POLL_DONE: if (pr_err_i || pr_done_i || poll_last) st_nxt = ST_TD_REQ;
            ST_TD_REQ:    st_nxt = ST_B_CLR0;
            ST_TD_PATH:   st_nxt = ST_TD_CS;
            ST_TD_CS:     st_nxt = ST_TD_OVR;
            ST_TD_OVR:    st_nxt = ST_FINAL;
            ST_FINAL:     st_nxt = ST_REPORT;
            ST_REPORT:    st_nxt = ST_IDLE;
            default:      st_nxt = ST_IDLE;
        endcase
    end

    // registered control flags, burst set-up and result bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q <= 1'b1;
            ovr_q  <= 1'b0;
            req_q  <= 1'b0;
            path_q <= 1'b0;
            len_q  <= '0;
            ret_q  <= ST_IDLE;
            err_q  <= RES_OK;
            res_q  <= RES_OK;
        end else begin
            case (st_q)
                ST_IDLE:    if (start_i) err_q <= RES_OK;
                ST_CHECK:   if (!entry_ok) res_q <= RES_INVALID;
                ST_CS_ON:   cs_n_q <= 1'b0;
                ST_PATH_ON: path_q <= 1'b1;
                ST_OVR_ON: begin
                    ovr_q <= 1'b1;
                    len_q <= LEN_W'(FLUSH_LEN);
                    ret_q <= ST_REQ_ON;
                end
                ST_REQ_ON: begin
                    req_q <= 1'b1;
                    len_q <= LEN_W'(PREP_LEN);
                    ret_q <= ST_POLL_RDY;
                end
                ST_POLL_RDY: begin
                    if (pr_err_i)                      err_q <= RES_INVALID;
                    else if (!pr_ready_i && poll_last) err_q <= RES_TIMEOUT;
                end
                ST_POLL_DONE: begin
                    if (pr_err_i)                     err_q <= RES_INVALID;
                    else if (!pr_done_i && poll_last) err_q <= RES_TIMEOUT;
                end
                ST_TD_REQ: begin
                    req_q <= 1'b0;
                    len_q <= LEN_W'(FLUSH_LEN);
                    ret_q <= ST_TD_PATH;
                end
                ST_TD_PATH: path_q <= 1'b0;
                ST_TD_CS:   cs_n_q <= 1'b1;
                ST_TD_OVR:  ovr_q  <= 1'b0;
                ST_FINAL: begin
                    if (err_q != RES_OK) res_q <= err_q;
                    else if (health_ok)  res_q <= RES_OK;
                    else                 res_q <= RES_TIMEOUT;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        brst_clr_o   = (st_q == ST_B_CLR0) || (st_q == ST_B_CLR1);
        brst_go_o    = (st_q == ST_B_GO);
        stream_ok_o  = (st_q == ST_STREAM);
        res_vld_o    = (st_q == ST_REPORT);
        busy_o       = (st_q != ST_IDLE);
        brst_len_o   = len_q;
        chip_sel_n_o = cs_n_q;
        ovr_en_o     = ovr_q;
        pr_req_o     = req_q;
        path_en_o    = path_q;
        res_code_o   = res_q;
        view_o       = view_w;
    end

endmodule

// File: rtl/prsess_ctrl_chk.sv
module prsess_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chip_sel_n_o,
    input logic       ovr_en_o,
    input logic       pr_req_o,
    input logic       path_en_o,
    input logic       brst_go_o,
    input logic       brst_clr_o,
    input logic       stream_ok_o,
    input logic       busy_o,
    input logic       res_vld_o,
    input logic [1:0] res_code_o,
    input logic       umode_i,
    input logic [2:0] view_o
);
    a_r3_path_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(path_en_o) |-> !chip_sel_n_o);

    a_r3_ovr_after_path: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_en_o) |-> (!chip_sel_n_o && path_en_o));

    a_r4_req_under_ovr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pr_req_o) |-> (ovr_en_o && path_en_o));

    a_r4_go_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
        brst_go_o |-> $past(brst_clr_o));

    a_r6_stream_in_session: assert property (@(posedge clk) disable iff (!rst_n)
        stream_ok_o |-> (pr_req_o && ovr_en_o && !chip_sel_n_o && path_en_o));

    a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!brst_go_o && !stream_ok_o && !res_vld_o));

    a_r8_path_off_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(path_en_o) |-> !pr_req_o);

    a_r8_cs_off_after_path: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_sel_n_o) |-> (!path_en_o && ovr_en_o));

    a_r8_ovr_off_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovr_en_o) |-> chip_sel_n_o);

    a_r10_clean_report: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> (chip_sel_n_o && !ovr_en_o && !path_en_o && !pr_req_o
                       && res_code_o != 2'd3));

    a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |=> !res_vld_o);

    a_r11_user_mode_wins: assert property (@(posedge clk) disable iff (!rst_n)
        umode_i |-> (view_o == 3'd1));

endmodule

bind prsess_ctrl prsess_ctrl_chk u_chk (.*);

// File: tb/sim_prsess_ctrl.sv
`timescale 1ns/1ps
module sim_prsess_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 0, finish_i = 0;
    logic [2:0]  msel_i = 0;
    logic        ncfg_pin_i = 1, nstat_pin_i = 1, cdone_pin_i = 1, umode_i = 1, crc_err_i = 0;
    logic        pr_ready_i = 0, pr_done_i = 0, pr_err_i = 0, brst_done_i = 0;
    logic        brst_go_o, brst_clr_o, chip_sel_n_o, ovr_en_o, pr_req_o, path_en_o;
    logic        stream_ok_o, busy_o, res_vld_o;
    logic [11:0] brst_len_o;
    logic [1:0]  res_code_o;
    logic [2:0]  view_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    prsess_ctrl u0 (.*);

    // one expected cycle: stimulus for that cycle and the outputs seen during it
    typedef struct {
        logic st, fin, rdy, dn, er, bd;
        logic go, clr, str, vld;
        logic csn, ovr, req, path, busy;
        logic [1:0] code;
        logic [11:0] len;
        string tag;
    } step_t;

    step_t q[$];

    logic       e_csn = 1, e_ovr = 0, e_req = 0, e_path = 0, e_busy = 0;
    logic [1:0] e_code = 0;
    logic [11:0] e_len = 0;

    task automatic push(string tag, logic go, logic clr, logic str, logic vld,
                        logic st, logic fin, logic rdy, logic dn, logic er, logic bd);
        step_t s;
        s.tag = tag; s.go = go; s.clr = clr; s.str = str; s.vld = vld;
        s.st = st; s.fin = fin; s.rdy = rdy; s.dn = dn; s.er = er; s.bd = bd;
        s.csn = e_csn; s.ovr = e_ovr; s.req = e_req; s.path = e_path;
        s.busy = e_busy; s.code = e_code; s.len = e_len;
        q.push_back(s);
    endtask

    task automatic burst(int lenv, int w);
        e_len = 12'(lenv);
        push("R4", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        push("R4", 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int k = 1; k < w; k++) push("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        push("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        push("R4", 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic play();
        step_t s;
        logic [10:0] act, exp;
        while (q.size() > 0) begin
            s = q.pop_front();
            @(negedge clk);
            act = {brst_go_o, brst_clr_o, stream_ok_o, res_vld_o, chip_sel_n_o,
                   ovr_en_o, pr_req_o, path_en_o, busy_o, res_code_o};
            exp = {s.go, s.clr, s.str, s.vld, s.csn, s.ovr, s.req, s.path, s.busy, s.code};
            n_checks++;
            if (act !== exp || (s.go && brst_len_o !== s.len)) begin
                n_errors++;
                $display("FAIL %s outputs act=%b len=%0d exp=%b len=%0d",
                         s.tag, act, brst_len_o, exp, s.len);
            end
            start_i = s.st; finish_i = s.fin; pr_ready_i = s.rdy;
            pr_done_i = s.dn; pr_err_i = s.er; brst_done_i = s.bd;
        end
    endtask

    // rmode/dmode: 0 = ready/done on poll n, 1 = error together with ready/done on poll n, 2 = never
    task automatic session(int rmode, int rn, int dmode, int dn_n, int nstr, int bw,
                           bit noise, logic [1:0] exp_code, string tag);
        bit inv;
        int n;
        inv = (msel_i > 3'd1) || !ncfg_pin_i || !nstat_pin_i;
        push("R10", 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        e_busy = 1;
        push(tag, 0, 0, 0, 0, 0, noise, 0, 0, 0, 0);          // CHECK
        if (inv) begin
            e_code = exp_code;
            push(tag, 0, 0, 0, 1, noise, 0, 0, 0, 0, 0);       // REPORT
            e_busy = 0;
            push(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
            play();
            return;
        end
        push("R3", 0, 0, 0, 0, noise, noise, 0, 0, 0, 0);     // CS_ON, R6 noise
        e_csn = 0;
        push("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);             // PATH_ON
        e_path = 1;
        push("R3", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);             // OVR_ON
        e_ovr = 1;
        burst(256, bw);
        push("R4", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);             // REQ_ON
        e_req = 1;
        burst(2047, bw);
        n = (rmode == 2) ? 10 : rn;
        for (int p = 1; p <= n; p++)
            push("R5", 0, 0, 0, 0, noise, noise, (p == n) && (rmode != 2), 0,
                 (p == n) && (rmode == 1), 0);
        if (rmode == 0) begin
            for (int c = 1; c <= nstr; c++)
                push("R6", 0, 0, 1, 0, noise, c == nstr, 0, 0, 0, 0);
            n = (dmode == 2) ? 10 : dn_n;
            for (int p = 1; p <= n; p++)
                push("R7", 0, 0, 0, 0, 0, noise, 0, (p == n) && (dmode != 2),
                     (p == n) && (dmode == 1), 0);
        end
        push("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);             // TD_REQ
        e_req = 0;
        burst(256, bw);
        push("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);             // TD_PATH
        e_path = 0;
        push("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);             // TD_CS
        e_csn = 1;
        push("R8", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);             // TD_OVR
        e_ovr = 0;
        push(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);              // FINAL
        e_code = exp_code;
        push(tag, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);              // REPORT
        e_busy = 0;
        push("R10", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        play();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        n_checks++;
        if ({chip_sel_n_o, ovr_en_o, pr_req_o, path_en_o, busy_o, res_vld_o, res_code_o} !== 8'b1000_0000) begin
            n_errors++;
            $display("FAIL R10 reset act=%b exp=%b",
                     {chip_sel_n_o, ovr_en_o, pr_req_o, path_en_o, busy_o, res_vld_o, res_code_o}, 8'b1000_0000);
        end

        msel_i = 3'd2; session(0, 1, 0, 1, 1, 1, 0, 2'd1, "R1");
        msel_i = 3'd7; session(0, 1, 0, 1, 1, 1, 1, 2'd1, "R1");
        msel_i = 3'd0; nstat_pin_i = 0; session(0, 1, 0, 1, 1, 1, 0, 2'd1, "R2");
        nstat_pin_i = 1; ncfg_pin_i = 0; session(0, 1, 0, 1, 1, 1, 0, 2'd1, "R2");
        ncfg_pin_i = 1;
        msel_i = 3'd1; session(0, 3, 0, 2, 4, 3, 1, 2'd0, "R10");
        msel_i = 3'd0; session(2, 0, 0, 1, 1, 1, 0, 2'd2, "R5");
        session(1, 4, 0, 1, 1, 2, 0, 2'd1, "R5");
        session(0, 10, 1, 5, 2, 1, 1, 2'd1, "R7");
        session(0, 1, 2, 0, 1, 2, 0, 2'd2, "R7");
        session(0, 1, 0, 10, 1, 1, 0, 2'd0, "R7");
        umode_i = 0; session(0, 2, 0, 2, 3, 1, 0, 2'd2, "R9");
        umode_i = 1; cdone_pin_i = 0; session(0, 2, 0, 2, 1, 1, 0, 2'd2, "R9");
        cdone_pin_i = 1; session(0, 1, 0, 1, 1, 1, 0, 2'd0, "R10");

        // R11 status view priority over all input combinations
        for (int v = 0; v < 16; v++) begin
            logic [2:0] ev;
            @(negedge clk);
            umode_i = v[3]; pr_ready_i = v[2]; crc_err_i = v[1]; nstat_pin_i = v[0];
            #1;
            if (v[3])       ev = 3'd1;
            else if (v[2])  ev = 3'd2;
            else if (v[1])  ev = 3'd3;
            else if (!v[0]) ev = 3'd4;
            else            ev = 3'd0;
            n_checks++;
            if (view_o !== ev) begin
                n_errors++;
                $display("FAIL R11 view act=%0d exp=%0d", view_o, ev);
            end
        end
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog act=running exp=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule